// File: doc/BRIEF.md
# Reverse Return-Stack Rebuilder

This block rebuilds the contents of a small return address stack after a stretch of execution that was skipped. It does not replay the calls and returns in program order. It walks a log of them from the newest entry to the oldest. A single balance counter tracks how many returns are still waiting to be matched:

- Every return seen on the backward walk raises the balance.
- A call seen while the balance is nonzero is the partner of a later return, so it lowers the balance and is dropped.
- A call seen while the balance is zero was never returned from, so its return address belongs on the final stack.

Because the walk runs newest-first, the first address captured is the top of the stack. Each later capture lands one level deeper.

A controller pulses `start_i` and then streams the log events over a valid/ready handshake. It marks the oldest event with `ev_last_i`. The block raises `done_o` at one of two points: as soon as every slot is filled, or after the marked event is consumed. Slots that were not reached keep whatever they held before.

Top module: `rrs_rebuilder`

## Requirements
- R1: After reset the outputs are as follows: `done_o` and `ev_ready_o` are 0, `fill_o` is 0, and every stack slot holds 0. The block waits for a start pulse.
- R2: An accepted event with `ev_is_push_i`=0 (a return) raises the balance by one and writes no slot.
- R3: An accepted event with `ev_is_push_i`=1 (a call) while the balance is zero stores `ev_addr_i` into slot `fill_o` and increments `fill_o`. Slot 0 (`stack_o[ADDR_W-1:0]`) is the top of stack, and slot k occupies bits `[k*ADDR_W +: ADDR_W]`.
- R4: An accepted call while the balance is nonzero lowers the balance by one. It writes no slot and leaves `fill_o` unchanged.
- R5: The capture that fills the last slot makes `fill_o` equal DEPTH. On the same clock edge, `done_o` rises and `ev_ready_o` falls.
- R6: An accepted event with `ev_last_i`=1 is processed normally and then sets `done_o`. Slots at or above `fill_o` keep their previous contents.
- R7: The balance is 16 bits wide and saturates at 65535. Further returns leave it at 65535, so after 65537 returns it takes 65535 calls to bring it back to zero.
- R8: While `done_o` is high, events are not accepted and the stack and `fill_o` do not change. A `start_i` pulse clears the balance and `fill_o` but keeps the slot contents.
- R9: `ev_ready_o` is high only between a start pulse and completion. An event is consumed only on a clock edge with both `ev_valid_i` and `ev_ready_o` high. A start pulse in mid-walk discards the balance accumulated so far.
- R10: With default parameters the stack holds 8 slots of 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a new rebuild |
| ev_valid_i | input | 1 | A log event is presented |
| ev_is_push_i | input | 1 | 1 = call (push with return address), 0 = return (pop) |
| ev_addr_i | input | ADDR_W | Return address carried by a call event |
| ev_last_i | input | 1 | Marks the oldest event of the log |
| ev_ready_o | output | 1 | Block accepts an event this cycle |
| stack_o | output | DEPTH*ADDR_W | Rebuilt stack, slot 0 (top) in the low bits |
| fill_o | output | $clog2(DEPTH+1) | Number of slots captured so far |
| done_o | output | 1 | Rebuild finished |

## Verification
The hardest behaviour to reach is saturation of the balance counter. It needs more than 65535 unmatched returns before any call, and only the effect on later calls is visible at the ports. The stimulus sends 65537 returns in a row, then 65535 calls that must all be dropped, then one more call that must be captured into the top slot. A wrapping counter would capture the second of those calls instead. Stale-slot retention is reached by first filling all eight slots in one rebuild and then ending a second rebuild after a single capture.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WALK = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/rrs_balance.sv
module rrs_balance #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    input  logic dec_i,
    output logic zero_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } bal_t;

    bal_t bal_d, bal_q;

    always_comb begin
        bal_d = bal_q;
        if (clr_i) begin
            bal_d.cnt = '0;
        end else if (inc_i) begin
            if (bal_q.cnt != CNT_MAX) bal_d.cnt = bal_q.cnt + 1'b1;
        end else if (dec_i) begin
            if (bal_q.cnt != '0) bal_d.cnt = bal_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bal_q <= '0;
        else        bal_q <= bal_d;
    end

    assign zero_o = (bal_q.cnt == '0);

    AST_BAL_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && inc_i && bal_q.cnt == CNT_MAX) |=> (bal_q.cnt == CNT_MAX)); // R7
    AST_BAL_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && dec_i && !inc_i && zero_o) |=> zero_o); // R4
endmodule

// File: rtl/rrs_slots.sv
module rrs_slots #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int FW     = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    wr_i,
    input  logic [ADDR_W-1:0]       wr_data_i,
    output logic [DEPTH*ADDR_W-1:0] stack_o,
    output logic [FW-1:0]           fill_o,
    output logic                    one_left_o,
    output logic                    full_o
);
    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] mem;
        logic [FW-1:0]                fill;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (clr_i) begin
            slot_d.fill = '0;
        end else if (wr_i && !full_o) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (slot_q.fill == FW'(i)) slot_d.mem[i] = wr_data_i;
            end
            slot_d.fill = slot_q.fill + FW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign stack_o    = slot_q.mem;
    assign fill_o     = slot_q.fill;
    assign full_o     = (slot_q.fill == FW'(DEPTH));
    assign one_left_o = (slot_q.fill == FW'(DEPTH - 1));

    AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q.fill <= FW'(DEPTH)); // R5
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(slot_q.mem)); // R6
endmodule

// File: rtl/rrs_ctrl.sv
module rrs_ctrl
    import rrs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ev_valid_i,
    input  logic ev_is_push_i,
    input  logic ev_last_i,
    input  logic bal_zero_i,
    input  logic one_left_i,
    output logic ready_o,
    output logic done_o,
    output logic clr_o,
    output logic bal_inc_o,
    output logic bal_dec_o,
    output logic slot_wr_o
);
    typedef struct packed {
        phase_e phase;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  take;

    always_comb begin
        ctrl_d    = ctrl_q;
        take      = !start_i && (ctrl_q.phase == PH_WALK) && ev_valid_i;
        clr_o     = start_i;
        bal_inc_o = take && !ev_is_push_i;
        bal_dec_o = take && ev_is_push_i && !bal_zero_i;
        slot_wr_o = take && ev_is_push_i && bal_zero_i;
        if (start_i) begin
            ctrl_d.phase = PH_WALK;
        end else if (take) begin
            if (ev_last_i || (slot_wr_o && one_left_i)) ctrl_d.phase = PH_DONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{phase: PH_IDLE};
        else        ctrl_q <= ctrl_d;
    end

    assign ready_o = (ctrl_q.phase == PH_WALK);
    assign done_o  = (ctrl_q.phase == PH_DONE);

    AST_READY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && done_o)); // R9
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R8
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ev_last_i) |=> done_o); // R6
endmodule

// File: rtl/rrs_rebuilder.sv
module rrs_rebuilder #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         ev_valid_i,
    input  logic                         ev_is_push_i,
    input  logic [ADDR_W-1:0]            ev_addr_i,
    input  logic                         ev_last_i,
    output logic                         ev_ready_o,
    output logic [DEPTH*ADDR_W-1:0]      stack_o,
    output logic [$clog2(DEPTH+1)-1:0]   fill_o,
    output logic                         done_o
);
    localparam int FW = $clog2(DEPTH + 1);

    logic clr, bal_inc, bal_dec, slot_wr, bal_zero, one_left, full;

    rrs_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .ev_valid_i   (ev_valid_i),
        .ev_is_push_i (ev_is_push_i),
        .ev_last_i    (ev_last_i),
        .bal_zero_i   (bal_zero),
        .one_left_i   (one_left),
        .ready_o      (ev_ready_o),
        .done_o       (done_o),
        .clr_o        (clr),
        .bal_inc_o    (bal_inc),
        .bal_dec_o    (bal_dec),
        .slot_wr_o    (slot_wr)
    );

    rrs_balance #(.CNT_W(CNT_W)) u_bal (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .inc_i  (bal_inc),
        .dec_i  (bal_dec),
        .zero_o (bal_zero)
    );

    rrs_slots #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .FW(FW)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .wr_i       (slot_wr),
        .wr_data_i  (ev_addr_i),
        .stack_o    (stack_o),
        .fill_o     (fill_o),
        .one_left_o (one_left),
        .full_o     (full)
    );

    logic accept;
    assign accept = ev_valid_i && ev_ready_o && !start_i;

    AST_POP_KEEPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ev_is_push_i) |=> $stable(fill_o)); // R2
    AST_CAPTURE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ev_is_push_i && bal_zero) |=> (fill_o == $past(fill_o) + FW'(1))); // R3
    AST_SKIP_KEEPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ev_is_push_i && !bal_zero) |=> $stable(fill_o)); // R4
    AST_FULL_MEANS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> done_o); // R5
    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(fill_o) && $stable(stack_o))); // R8
endmodule

// File: tb/sim_rrs_rebuilder.sv
module sim_rrs_rebuilder;
    localparam int DEPTH = 8;
    localparam int AW    = 32;
    localparam int MAXB  = 65535;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              ev_valid_i = 1'b0;
    logic              ev_is_push_i = 1'b0;
    logic [AW-1:0]     ev_addr_i = '0;
    logic              ev_last_i = 1'b0;
    logic              ev_ready_o;
    logic [DEPTH*AW-1:0] stack_o;
    logic [3:0]        fill_o;
    logic              done_o;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [DEPTH*AW-1:0] m_stack = '0;
    int m_fill = 0;
    int m_bal  = 0;
    bit m_walk = 0;
    bit m_done = 0;

    always #5 clk = ~clk;

    rrs_rebuilder u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ev_valid_i(ev_valid_i),
        .ev_is_push_i(ev_is_push_i), .ev_addr_i(ev_addr_i), .ev_last_i(ev_last_i),
        .ev_ready_o(ev_ready_o), .stack_o(stack_o), .fill_o(fill_o), .done_o(done_o)
    );

    task automatic check_state(input string tag);
        tests++;
        if (done_o !== m_done || ev_ready_o !== m_walk || fill_o !== 4'(m_fill)
            || stack_o !== m_stack) begin
            fails++;
            $display("FAIL %s: done=%0b/%0b ready=%0b/%0b fill=%0d/%0d stack=%h/%h",
                     tag, done_o, m_done, ev_ready_o, m_walk, fill_o, m_fill,
                     stack_o, m_stack);
        end
    endtask

    task automatic do_start();
        @(negedge clk);
        start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        m_walk = 1; m_done = 0; m_bal = 0; m_fill = 0;
    endtask

    task automatic send(input bit push, input logic [AW-1:0] addr, input bit last);
        @(negedge clk);
        ev_valid_i = 1'b1; ev_is_push_i = push; ev_addr_i = addr; ev_last_i = last;
        @(posedge clk);
        #1 ev_valid_i = 1'b0; ev_last_i = 1'b0;
        if (m_walk) begin
            if (!push) begin
                if (m_bal < MAXB) m_bal++;
            end else if (m_bal == 0) begin
                m_stack[m_fill*AW +: AW] = addr;
                m_fill++;
                if (m_fill == DEPTH) m_done = 1;
            end else begin
                m_bal--;
            end
            if (last) m_done = 1;
            if (m_done) m_walk = 0;
        end
    endtask

    task automatic t_reset();
        check_state("R1 reset state");
        send(1'b1, 32'hDEAD0001, 1'b0);
        check_state("R9 event ignored before start");
    endtask

    task automatic t_basic();
        do_start();
        check_state("R9 ready after start");
        send(1'b1, 32'h0000A000, 1'b0);
        check_state("R3 first capture is top");
        send(1'b0, '0, 1'b0);
        send(1'b0, '0, 1'b0);
        check_state("R2 pops write nothing");
        send(1'b1, 32'h0000B000, 1'b0);
        send(1'b1, 32'h0000C000, 1'b0);
        check_state("R4 matched calls skipped");
        send(1'b1, 32'h0000D000, 1'b0);
        check_state("R3 second capture goes deeper");
        send(1'b0, '0, 1'b1);
        check_state("R6 last marker ends walk");
    endtask

    task automatic t_fill();
        do_start();
        for (int i = 0; i < DEPTH; i++) begin
            send(1'b1, 32'h10000000 + 32'(i * 16), 1'b0);
            if (i == DEPTH - 2) check_state("R5 one slot left, still walking");
        end
        check_state("R5 R10 full stack of 8 sets done");
        send(1'b1, 32'hBAD00000, 1'b0);
        check_state("R8 push ignored after done");
        send(1'b0, '0, 1'b1);
        check_state("R8 pop ignored after done");
    endtask

    task automatic t_stale();
        do_start();
        check_state("R8 start clears fill keeps slots");
        send(1'b1, 32'h0000E000, 1'b1);
        check_state("R6 uncaptured slots stay stale");
    endtask

    task automatic t_restart();
        do_start();
        send(1'b0, '0, 1'b0);
        send(1'b0, '0, 1'b0);
        do_start();
        send(1'b1, 32'h0000F000, 1'b0);
        check_state("R9 restart discards balance");
        @(negedge clk);
        ev_valid_i = 1'b0; ev_is_push_i = 1'b1; ev_addr_i = 32'h12345678;
        @(posedge clk);
        #1;
        check_state("R9 no valid means no capture");
    endtask

    task automatic t_saturate();
        do_start();
        for (int i = 0; i < MAXB + 2; i++) send(1'b0, '0, 1'b0);
        for (int i = 0; i < MAXB; i++) send(1'b1, 32'h77770000, 1'b0);
        check_state("R7 saturated balance absorbs 65535 calls");
        send(1'b1, 32'h0000C0DE, 1'b1);
        check_state("R7 next call captured after saturation");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_fill();
        t_stale();
        t_restart();
        t_saturate();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, got hang expected end");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule